// File: doc/BRIEF.md
# Serial-Loaded Bias DAC Code Register

This block is the digital front end of a programmable bias supply. It takes a write-only three-wire serial stream: an active-low select, a serial clock and a data line. From it, the block assembles one 8-bit setting per frame and holds that setting in a code register. The register drives the digital-to-analog stage of the supply. A code of zero is not treated as the lowest output: it switches the converter off, and the block raises a shutdown flag for it.

All three serial lines are asynchronous to the system clock. They pass through synchronizers and edge detectors, and every decision is made in the system clock domain. A frame commits only when select returns high, and only if exactly eight serial clock rises were seen while select was low. Any other frame is discarded. The block also exports a behavioural output level in microvolts for checking.

There is no read path. The serial port keeps accepting frames while the converter is shut down.

Top module: `bias_code_serial_reg`

## Requirements
- R1: After reset the code output is 0xFF, the shutdown flag is low and the load strobe is low, even if reset hits in the middle of a frame.
- R2: Data is sampled on each rising serial clock edge while select is low and shifted in most significant bit first. A frame with exactly 8 such edges loads the 8 bits, the first one received landing in bit 7, into the code output.
- R3: The code output does not change while select is low; a new code appears only after select returns high.
- R4: A frame with fewer or more than 8 sampled edges, including a frame with none, is discarded: the code keeps its value and no strobe is issued.
- R5: The shutdown flag is high exactly when the code output is 0x00; every other code enables the converter.
- R6: The load strobe is high for one system clock cycle for each committed frame, also when the new code equals the old one.
- R7: Frames are accepted and committed while the shutdown flag is high.
- R8: The level output equals floor((code + 1) * 1250000 / 256) microvolts, so 0xFF gives 1250000.
- R9: A serial clock rise that is sampled in the same system clock cycle as the rise of select is not counted as a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdin | input | 1 | Serial data, asynchronous |
| code_o | output | 8 | Committed DAC code |
| shdn_o | output | 1 | Converter shutdown flag (code is zero) |
| load_o | output | 1 | One-cycle pulse per committed code |
| level_uv_o | output | 21 | Behavioural output level in microvolts |

## Verification
The end of a frame and its last bit can fall in the same system clock cycle. This happens when the final serial clock rise and the select rise pass through the synchronizers together. The bench provokes this by switching both lines at the same instant. With eight bits sent, the edge is lost: the frame counts seven and is dropped, and the code stays the same. With nine bits sent, eight are counted, and the code becomes the first eight bits of the nine.

// File: rtl/bias_code_pkg.sv
package bias_code_pkg;
  localparam int unsigned CODE_W_DEF  = 8;
  localparam int unsigned FS_UV_DEF   = 1250000;
  localparam int unsigned LVL_W_DEF   = 21;
  localparam int unsigned SYNC_DEF    = 2;

  function automatic int unsigned cnt_width(input int unsigned bits);
    return $clog2(bits + 2);
  endfunction
endpackage

// File: rtl/line_sync_edge.sv
module line_sync_edge #(
  parameter int unsigned LINES  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic              prev_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain_q <= '1;
        prev_q  <= 1'b1;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], raw_i[g]};
        prev_q  <= chain_q[STAGES-1];
      end
    end
    assign lvl_o[g]  = chain_q[STAGES-1];
    assign rise_o[g] = chain_q[STAGES-1] & ~prev_q;
    assign fall_o[g] = ~chain_q[STAGES-1] & prev_q;
  end
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_lvl_i,
  input  logic              sel_rise_i,
  input  logic              sel_fall_i,
  input  logic              bit_edge_i,
  input  logic              din_i,
  output logic [CODE_W-1:0] data_o,
  output logic              commit_o
);
  localparam int unsigned CW  = bias_code_pkg::cnt_width(CODE_W);
  localparam logic [CW-1:0] SAT = CW'(CODE_W + 1);
  localparam logic [CW-1:0] LEN = CW'(CODE_W);

  logic [CW-1:0]     cnt_q;
  logic [CODE_W-1:0] sh_q;
  logic              commit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (sel_fall_i) begin
        cnt_q <= '0;
      end else if (!sel_lvl_i && bit_edge_i) begin
        sh_q <= {sh_q[CODE_W-2:0], din_i};
        if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
      end
      if (sel_rise_i) commit_q <= (cnt_q == LEN);
    end
  end

  assign data_o   = sh_q;
  assign commit_o = commit_q;
endmodule

// File: rtl/code_register.sv
module code_register #(
  parameter int unsigned       CODE_W   = 8,
  parameter int unsigned       LVL_W    = 21,
  parameter int unsigned       FS_UV    = 1250000,
  parameter logic [CODE_W-1:0] RST_CODE = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_i,
  input  logic [CODE_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o,
  output logic              shdn_o,
  output logic              load_o,
  output logic [LVL_W-1:0]  level_o
);
  localparam int unsigned PW = LVL_W + CODE_W + 1;

  function automatic logic [LVL_W-1:0] to_level(input logic [CODE_W-1:0] c);
    logic [PW-1:0] prod;
    prod = (PW'(c) + PW'(1)) * PW'(FS_UV);
    return LVL_W'(prod >> CODE_W);
  endfunction

  logic [CODE_W-1:0] code_q;
  logic              shdn_q, load_q;
  logic [LVL_W-1:0]  lvl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= RST_CODE;
      shdn_q <= (RST_CODE == '0);
      lvl_q  <= to_level(RST_CODE);
      load_q <= 1'b0;
    end else begin
      load_q <= commit_i;
      if (commit_i) begin
        code_q <= data_i;
        shdn_q <= (data_i == '0);
        lvl_q  <= to_level(data_i);
      end
    end
  end

  assign code_o  = code_q;
  assign shdn_o  = shdn_q;
  assign load_o  = load_q;
  assign level_o = lvl_q;

  // R6: a strobe never lasts two cycles
  a_r6_strobe_single: assert property (@(posedge clk) disable iff (rst)
    load_q |=> !load_q);

  // R5: shutdown flag tracks a zero code
  a_r5_shdn_match: assert property (@(posedge clk) disable iff (rst)
    shdn_q == (code_q == '0));
endmodule

// File: rtl/bias_code_serial_reg.sv
module bias_code_serial_reg #(
  parameter int unsigned CODE_W = bias_code_pkg::CODE_W_DEF,
  parameter int unsigned LVL_W  = bias_code_pkg::LVL_W_DEF,
  parameter int unsigned FS_UV  = bias_code_pkg::FS_UV_DEF,
  parameter int unsigned SYNC   = bias_code_pkg::SYNC_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              sclk,
  input  logic              sdin,
  output logic [CODE_W-1:0] code_o,
  output logic              shdn_o,
  output logic              load_o,
  output logic [LVL_W-1:0]  level_uv_o
);
  localparam int unsigned IX_SEL = 2;
  localparam int unsigned IX_CLK = 1;
  localparam int unsigned IX_DIN = 0;

  logic [2:0]        lvl, rise, fall;
  logic [CODE_W-1:0] frame_data;
  logic              frame_commit;

  line_sync_edge #(.LINES(3), .STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .raw_i({sel_n, sclk, sdin}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  frame_shifter #(.CODE_W(CODE_W)) u_frame (
    .clk(clk), .rst(rst),
    .sel_lvl_i(lvl[IX_SEL]), .sel_rise_i(rise[IX_SEL]), .sel_fall_i(fall[IX_SEL]),
    .bit_edge_i(rise[IX_CLK]), .din_i(lvl[IX_DIN]),
    .data_o(frame_data), .commit_o(frame_commit)
  );

  code_register #(.CODE_W(CODE_W), .LVL_W(LVL_W), .FS_UV(FS_UV), .RST_CODE('1)) u_code (
    .clk(clk), .rst(rst), .commit_i(frame_commit), .data_i(frame_data),
    .code_o(code_o), .shdn_o(shdn_o), .load_o(load_o), .level_o(level_uv_o)
  );

  // R3: no code change while the synchronized select is low
  a_r3_hold_while_selected: assert property (@(posedge clk) disable iff (rst)
    !lvl[IX_SEL] |=> $stable(code_o));

  // R1: first cycle out of reset shows the reset state
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (code_o == '1 && !shdn_o && !load_o));
endmodule

// File: tb/bias_code_serial_reg_bench.sv
module bias_code_serial_reg_bench;
  logic clk = 1'b0, rst = 1'b1, sel_n = 1'b1, sclk = 1'b0, sdin = 1'b0;
  logic [7:0]  code_o;
  logic        shdn_o, load_o;
  logic [20:0] level_uv_o;
  int n_run = 0, n_fail = 0, n_load = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  bias_code_serial_reg u_bias_code_serial_reg (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sclk(sclk), .sdin(sdin),
    .code_o(code_o), .shdn_o(shdn_o), .load_o(load_o), .level_uv_o(level_uv_o)
  );

  always @(posedge clk) if (!rst && load_o) n_load <= n_load + 1;

  // {nbits[3:0], word[15:0], expected code[7:0]}
  localparam logic [27:0] VEC [9] = '{
    {4'd8, 16'h005A, 8'h5A},  // R2
    {4'd8, 16'h0000, 8'h00},  // R5 shutdown
    {4'd8, 16'h003C, 8'h3C},  // R7 accepted in shutdown
    {4'd7, 16'h0055, 8'h3C},  // R4 short
    {4'd9, 16'h01F0, 8'h3C},  // R4 long
    {4'd8, 16'h0080, 8'h80},
    {4'd8, 16'h0080, 8'h80},  // R6 same value strobes
    {4'd0, 16'h0000, 8'h80},  // R4 empty
    {4'd8, 16'h00FF, 8'hFF}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int nbits, input logic [15:0] w, input bit simul);
    sel_n = 1'b0;
    wclk(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdin = w[i];
      sclk = 1'b0;
      wclk(4);
      sclk = 1'b1;
      if (simul && i == 0) sel_n = 1'b1;
      wclk(4);
    end
    sclk = 1'b0;
    wclk(4);
    sel_n = 1'b1;
    wclk(10);
  endtask

  function automatic int lvl_of(input int c);
    return ((c + 1) * 1250000) / 256;
  endfunction

  task automatic check_state(input string req, input int exp_code, input int exp_loads);
    chk({req, " code"}, int'(code_o), exp_code);
    chk("R5 shutdown flag", int'(shdn_o), int'(exp_code == 0));
    chk("R8 level", int'(level_uv_o), lvl_of(exp_code));
    chk({req, " strobes"}, n_load, exp_loads);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int loads = 0;
    wclk(3);
    rst = 1'b0;
    wclk(2);
    // R1 reset state
    check_state("R1", 8'hFF, 0);
    chk("R1 strobe low", int'(load_o), 0);

    foreach (VEC[k]) begin
      int nb, ec;
      nb = int'(VEC[k][27:24]);
      ec = int'(VEC[k][7:0]);
      send(nb, VEC[k][23:8], 1'b0);
      if (nb == 8) loads++;
      check_state((nb == 8) ? "R2" : "R4", ec, loads);
    end

    // R9: last edge coincides with select rise, 8 sent -> 7 counted, dropped
    send(8, 16'h0011, 1'b1);
    check_state("R9 drop", 8'hFF, loads);
    // R9: 9 sent with coincident last edge -> first 8 bits committed
    send(9, 16'h01A5, 1'b1);
    loads++;
    check_state("R9 commit", 8'hD2, loads);

    // R3: mid-frame the code holds its value
    sel_n = 1'b0;
    wclk(4);
    for (int i = 7; i >= 0; i--) begin
      sdin = 1'b0; sclk = 1'b0; wclk(4); sclk = 1'b1; wclk(4);
    end
    sclk = 1'b0;
    wclk(8);
    chk("R3 hold while selected", int'(code_o), 8'hD2);
    sel_n = 1'b1;
    wclk(10);
    loads++;
    check_state("R3 commit after release", 8'h00, loads);

    // R1: reset in the middle of a frame
    sel_n = 1'b0;
    wclk(4);
    sdin = 1'b1; sclk = 1'b1; wclk(4); sclk = 1'b0;
    rst = 1'b1;
    wclk(2);
    rst = 1'b0;
    sel_n = 1'b1;
    wclk(10);
    chk("R1 code after reset", int'(code_o), 8'hFF);
    chk("R1 shutdown after reset", int'(shdn_o), 0);
    chk("R1 strobe after reset", int'(load_o), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule